// File: doc/BRIEF.md
# Triggered Circular Trace Buffer

This block keeps a rolling history of a wide sample vector in a circular store. A 3-bit rate code sets how often a vector is captured, from every clock down to one clock in sixteen. Capture happens only while the enable input is high. When a trigger is accepted, the block keeps capturing for a programmed number of further vectors, then freezes the store and raises a trigger-found flag. The trigger therefore sits at a known age inside the frozen history.

A readout command then streams the most recent 2^(5+len) vectors out of the frozen store, oldest first. Each vector goes out as four 32-bit words, and the final word carries a last marker. After the stream ends, the block either returns to capturing by itself (automatic re-arm) or waits in the frozen state for an explicit re-arm. Vectors are numbered by age: the newest stored vector is number 0.

Top module: `trace_buffer`

## Requirements
- R1: After reset the trigger-found flag is 0, no word is presented (outValid is 0), and the block is capturing.
- R2: A free-running counter starts at 0 after reset and advances every clock. A vector is captured on the clocks where that counter is a multiple of the period. rateCode 1xx gives period 1, 011 gives 2, 010 gives 4, 001 gives 8 and 000 gives 16.
- R3: While enable is 0 no vector is stored and no trigger is accepted.
- R4: The trigger-found flag is 0 while capturing. It becomes 1 on the clock after a trigger is accepted and stays 1 through the post-trigger phase, the frozen state and the readout.
- R5: After an accepted trigger, exactly P further vectors are stored and then capture stops. P is 16 times posCode, and posCode 0 counts as 16. A vector captured in the trigger cycle itself therefore has age number P in the frozen store.
- R6: A readout outputs N = 2^(5+lenCode) vectors: the N newest stored vectors.
- R7: Each vector is sent as 4 words on consecutive clocks, bits 31:0 first and bits 127:96 last. Vectors go oldest first, outValid stays high for the whole stream, and outLast is high only on its final word.
- R8: A readout command is acted on only in the frozen state after a trigger. It is ignored while capturing, during the post-trigger phase (including the cycle in which the last post-trigger vector is stored) and during a readout.
- R9: With autoRearm set, the flag returns to 0 together with the final word, and capture resumes on the next clock.
- R10: An explicit re-arm clears the flag and returns to capturing from the post-trigger phase or the frozen state. It is ignored during a readout, and a trigger in the same cycle as a re-arm is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture enable |
| rateCode | input | 3 | Capture rate selection |
| lenCode | input | 2 | Readout length code, N = 2^(5+lenCode) vectors |
| posCode | input | 4 | Post-trigger distance in units of 16 vectors (0 means 16) |
| autoRearm | input | 1 | Resume capture automatically after a readout |
| sampleIn | input | 128 | Sample vector |
| trigIn | input | 1 | Trigger event |
| readCmd | input | 1 | Readout command |
| rearmCmd | input | 1 | Explicit re-arm command |
| outValid | output | 1 | Output word valid |
| outWord | output | 32 | Output word |
| outLast | output | 1 | Final word of a readout |
| trigFound | output | 1 | Trigger-found status flag |

## Verification
Two events can fall on the same clock and need a defined outcome. The first is a readout command landing on the cycle that stores the last post-trigger vector. The second is a re-arm arriving together with a trigger. The bench places the readout command on exactly that storing cycle and expects no word to appear while the flag stays at 1. A later readout must still return the history that a bench model predicts. In the second case the bench expects the flag to stay at 0 and capture to continue.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;

  typedef enum logic [1:0] {
    ST_REC  = 2'd0,
    ST_POST = 2'd1,
    ST_DONE = 2'd2,
    ST_READ = 2'd3
  } tbState_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic rdLast;
  } tbStrobe_t;

endpackage

// File: rtl/tbuf_dp.sv
module tbuf_dp
  import tbuf_pkg::*;
#(
  parameter int SAMPLE_W = 128,
  parameter int ADDR_W   = 8,
  parameter int WORD_W   = 32,
  localparam int WORDS   = SAMPLE_W / WORD_W,
  localparam int SEL_W   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          rateCode,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  tbStrobe_t           strb,
  input  logic [ADDR_W-1:0]   rdBack,
  input  logic [SEL_W-1:0]    rdWord,
  output logic                sampleTick,
  output logic                outValid,
  output logic [WORD_W-1:0]   outWord,
  output logic                outLast
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [3:0]          divCnt;
  logic [3:0]          divMask;
  logic [ADDR_W-1:0]   wrPtr;
  logic [ADDR_W-1:0]   rdAddr;
  logic [SAMPLE_W-1:0] rdVec;
  logic [SAMPLE_W-1:0] store [DEPTH];

  // decimation: period mask picked by a priority code
  always_comb begin
    if (rateCode[2]) divMask = 4'b0000;
    else begin
      unique case (rateCode[1:0])
        2'b11:   divMask = 4'b0001;
        2'b10:   divMask = 4'b0011;
        2'b01:   divMask = 4'b0111;
        default: divMask = 4'b1111;
      endcase
    end
  end

  assign sampleTick = ((divCnt & divMask) == 4'b0000);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 4'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wrPtr <= '0;
    else if (strb.wrEn) wrPtr <= wrPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) store[wrPtr] <= sampleIn;
  end

  // readout address counted back from the next write slot
  assign rdAddr = wrPtr - rdBack;
  assign rdVec  = store[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outWord  <= '0;
    end else begin
      outValid <= strb.rdEn;
      outLast  <= strb.rdEn & strb.rdLast;
      if (strb.rdEn) outWord <= rdVec[rdWord*WORD_W +: WORD_W];
    end
  end

  // R2: at the slowest rate two ticks never follow each other
  p_slow_rate_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rateCode == 3'b000 && sampleTick) |=> (!sampleTick || rateCode != 3'b000));

  // R7: last marker only on a presented word
  p_last_has_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R5: store is frozen while words stream out
  p_frozen_stream_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $stable(wrPtr));

endmodule

// File: rtl/tbuf_ctrl.sv
module tbuf_ctrl
  import tbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int POS_W  = 4,
  parameter int LEN_W  = 2,
  parameter int WORDS  = 4,
  localparam int SEL_W = $clog2(WORDS),
  localparam int CNT_W = POS_W + 4,
  localparam int IDX_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sampleTick,
  input  logic [LEN_W-1:0]  lenCode,
  input  logic [POS_W-1:0]  posCode,
  input  logic              autoRearm,
  input  logic              trigIn,
  input  logic              readCmd,
  input  logic              rearmCmd,
  output tbStrobe_t         strb,
  output logic [ADDR_W-1:0] rdBack,
  output logic [SEL_W-1:0]  rdWord,
  output logic              trigFound
);
  tbState_e          state;
  logic [CNT_W-1:0]  postCnt;
  logic [CNT_W-1:0]  postLen;
  logic [CNT_W-1:0]  postTarget;
  logic [IDX_W-1:0]  rdIdx;
  logic [IDX_W-1:0]  rdLen;
  logic [IDX_W-1:0]  lenCount;
  logic [SEL_W-1:0]  wordCnt;
  logic              lastWord;

  assign postTarget = (posCode == '0) ? CNT_W'(16) : {posCode, 4'b0000};
  assign lenCount   = IDX_W'(32) << lenCode;
  assign lastWord   = (wordCnt == SEL_W'(WORDS - 1));

  assign strb.wrEn   = sampleTick & enable & (state == ST_REC || state == ST_POST);
  assign strb.rdEn   = (state == ST_READ);
  assign strb.rdLast = lastWord && (rdIdx == rdLen - 1'b1);
  assign rdBack      = ADDR_W'(rdLen - rdIdx);
  assign rdWord      = wordCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_REC;
      trigFound <= 1'b0;
      postCnt   <= '0;
      postLen   <= '0;
      rdIdx     <= '0;
      rdLen     <= '0;
      wordCnt   <= '0;
    end else begin
      unique case (state)
        ST_REC: begin
          if (!rearmCmd && trigIn && enable) begin
            state     <= ST_POST;
            trigFound <= 1'b1;
            postCnt   <= '0;
            postLen   <= postTarget;
          end
        end
        ST_POST: begin
          if (rearmCmd) begin
            state     <= ST_REC;
            trigFound <= 1'b0;
          end else if (strb.wrEn) begin
            postCnt <= postCnt + 1'b1;
            if (postCnt == postLen - 1'b1) state <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (rearmCmd) begin
            state     <= ST_REC;
            trigFound <= 1'b0;
          end else if (readCmd) begin
            state   <= ST_READ;
            rdIdx   <= '0;
            wordCnt <= '0;
            rdLen   <= lenCount;
          end
        end
        default: begin
          wordCnt <= wordCnt + 1'b1;
          if (lastWord) rdIdx <= rdIdx + 1'b1;
          if (strb.rdLast) begin
            if (autoRearm) begin
              state     <= ST_REC;
              trigFound <= 1'b0;
            end else begin
              state <= ST_DONE;
            end
          end
        end
      endcase
    end
  end

  // R10: re-arm outside a readout drops the flag
  p_rearm_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rearmCmd && state != ST_READ) |=> !trigFound);

  // R8: readout cannot start before capture has stopped
  p_read_needs_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (readCmd && (state == ST_REC || state == ST_POST)) |=> state != ST_READ);

  // R4: flag is up throughout a readout
  p_flag_in_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ) |-> trigFound);

  // R5: post-trigger phase advances only on stored vectors
  p_post_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POST && !strb.wrEn && !rearmCmd) |=> state == ST_POST);

endmodule

// File: rtl/trace_buffer.sv
module trace_buffer
  import tbuf_pkg::*;
#(
  parameter int SAMPLE_W = 128,
  parameter int ADDR_W   = 8,
  parameter int POS_W    = 4,
  parameter int LEN_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [2:0]          rateCode,
  input  logic [LEN_W-1:0]    lenCode,
  input  logic [POS_W-1:0]    posCode,
  input  logic                autoRearm,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                trigIn,
  input  logic                readCmd,
  input  logic                rearmCmd,
  output logic                outValid,
  output logic [31:0]         outWord,
  output logic                outLast,
  output logic                trigFound
);
  localparam int WORD_W = 32;
  localparam int WORDS  = SAMPLE_W / WORD_W;
  localparam int SEL_W  = $clog2(WORDS);

  tbStrobe_t         strb;
  logic [ADDR_W-1:0] rdBack;
  logic [SEL_W-1:0]  rdWord;
  logic              sampleTick;

  tbuf_ctrl #(
    .ADDR_W(ADDR_W), .POS_W(POS_W), .LEN_W(LEN_W), .WORDS(WORDS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleTick(sampleTick),
    .lenCode(lenCode), .posCode(posCode), .autoRearm(autoRearm),
    .trigIn(trigIn), .readCmd(readCmd), .rearmCmd(rearmCmd),
    .strb(strb), .rdBack(rdBack), .rdWord(rdWord), .trigFound(trigFound)
  );

  tbuf_dp #(
    .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rateCode(rateCode), .sampleIn(sampleIn),
    .strb(strb), .rdBack(rdBack), .rdWord(rdWord), .sampleTick(sampleTick),
    .outValid(outValid), .outWord(outWord), .outLast(outLast)
  );

  // R1: nothing is presented while reset is applied
  always_comb begin
    if (!rstN) a_reset_quiet_r1: assert (!outValid && !trigFound);
  end

endmodule

// File: tb/trace_buffer_tb.sv
module trace_buffer_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         enable = 1'b0;
  logic [2:0]   rateCode = 3'b100;
  logic [1:0]   lenCode = 2'd0;
  logic [3:0]   posCode = 4'd1;
  logic         autoRearm = 1'b0;
  logic [127:0] sampleIn = '0;
  logic         trigIn = 1'b0;
  logic         readCmd = 1'b0;
  logic         rearmCmd = 1'b0;
  logic         outValid;
  logic [31:0]  outWord;
  logic         outLast;
  logic         trigFound;

  int nChecks = 0;
  int nFails = 0;
  int tbCyc = 0;

  trace_buffer u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .rateCode(rateCode),
    .lenCode(lenCode), .posCode(posCode), .autoRearm(autoRearm),
    .sampleIn(sampleIn), .trigIn(trigIn), .readCmd(readCmd),
    .rearmCmd(rearmCmd), .outValid(outValid), .outWord(outWord),
    .outLast(outLast), .trigFound(trigFound)
  );

  always #10 clk = ~clk;

  function automatic logic [127:0] pattern(int c);
    logic [31:0] u = c;
    return {u ^ 32'hA5A5_0000, u * 32'd3, ~u, u};
  endfunction

  always @(negedge clk) begin
    tbCyc++;
    sampleIn <= pattern(tbCyc);
  end

  // ---------------- reference model ----------------
  localparam int M_REC = 0, M_POST = 1, M_DONE = 2, M_READ = 3;
  int mState, mFlag, divM, wrTot, mCnt, mP, mLeft;
  logic [127:0] hist [512];
  logic [31:0] expQ [$];
  logic [31:0] gotQ [$];
  int lastCnt = 0;
  int lastAt = -1;

  function automatic int periodMask(logic [2:0] r);
    if (r[2]) return 0;
    case (r[1:0])
      2'b11: return 1;
      2'b10: return 3;
      2'b01: return 7;
      default: return 15;
    endcase
  endfunction

  always @(posedge clk) begin
    int msk;
    bit tick, wr;
    if (!rstN) begin
      divM = 0; wrTot = 0; mState = M_REC; mFlag = 0; mCnt = 0; mP = 16; mLeft = 0;
    end else begin
      msk = periodMask(rateCode);
      tick = ((divM & msk) == 0);
      divM = (divM + 1) % 16;
      wr = tick && enable && (mState == M_REC || mState == M_POST);
      if (wr) begin hist[wrTot % 512] = sampleIn; wrTot++; end
      case (mState)
        M_REC: if (!rearmCmd && trigIn && enable) begin
          mState = M_POST; mFlag = 1; mCnt = 0;
          mP = (posCode == 0) ? 16 : 16 * int'(posCode);
        end
        M_POST: if (rearmCmd) begin mState = M_REC; mFlag = 0; end
                else if (wr) begin mCnt++; if (mCnt == mP) mState = M_DONE; end
        M_DONE: if (rearmCmd) begin mState = M_REC; mFlag = 0; end
                else if (readCmd) begin
                  int n;
                  n = 32 << lenCode;
                  mState = M_READ; mLeft = 4 * n;
                  expQ.delete();
                  for (int k = 0; k < n; k++)
                    for (int w = 0; w < 4; w++)
                      expQ.push_back(hist[(wrTot - n + k + 512) % 512][w*32 +: 32]);
                end
        default: begin
          mLeft--;
          if (mLeft == 0) begin
            if (autoRearm) begin mState = M_REC; mFlag = 0; end
            else mState = M_DONE;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && outValid) begin
      gotQ.push_back(outWord);
      if (outLast) begin lastCnt++; lastAt = gotQ.size() - 1; end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic checkEq(string tag, longint got, longint exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic pulseTrig();
    @(negedge clk); enable = 1'b1; trigIn = 1'b1;
    @(negedge clk); trigIn = 1'b0;
  endtask

  task automatic pulseRearm();
    @(negedge clk); rearmCmd = 1'b1;
    @(negedge clk); rearmCmd = 1'b0;
  endtask

  task automatic waitDone(bit randEn);
    int guard = 0;
    while (mState != M_DONE && guard < 20000) begin
      @(negedge clk);
      if (randEn) enable = (($urandom % 8) != 0);
      guard++;
    end
    enable = 1'b1;
    checkEq("R5 capture stops after post-trigger count", (mState == M_DONE), 1);
  endtask

  task automatic doRead(logic [1:0] len, string tag);
    gotQ.delete(); lastCnt = 0; lastAt = -1;
    @(negedge clk); lenCode = len; readCmd = 1'b1;
    @(negedge clk); readCmd = 1'b0;
    while (mState == M_READ) @(negedge clk);
    @(negedge clk);
    @(posedge clk);
    checkEq({tag, " R6 word count"}, gotQ.size(), expQ.size());
    begin
      int bad = 0;
      int firstBad = -1;
      for (int i = 0; i < gotQ.size() && i < expQ.size(); i++)
        if (gotQ[i] !== expQ[i]) begin bad++; if (firstBad < 0) firstBad = i; end
      if (firstBad >= 0)
        checkEq({tag, " R7 stream content"}, gotQ[firstBad], expQ[firstBad]);
      else checkEq({tag, " R7 stream content"}, 0, 0);
    end
    checkEq({tag, " R7 single last"}, lastCnt, 1);
    checkEq({tag, " R7 last position"}, lastAt, gotQ.size() - 1);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int seedDummy;
    logic [127:0] trigSample;
    seedDummy = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 reset outValid", outValid, 0);
    checkEq("R1 reset flag", trigFound, 0);

    // warm-up fill at full rate
    enable = 1'b1; rateCode = 3'b101;
    repeat (300) @(negedge clk);
    checkEq("R4 flag low while capturing", trigFound, 0);

    // R8: readout while capturing is ignored
    gotQ.delete();
    @(negedge clk); readCmd = 1'b1;
    @(negedge clk); readCmd = 1'b0;
    repeat (6) @(negedge clk);
    checkEq("R8 read ignored while capturing", gotQ.size(), 0);

    // R5/R6/R7 directed: trigger vector age
    posCode = 4'd2; autoRearm = 1'b0;
    @(negedge clk); trigIn = 1'b1;
    #1 trigSample = sampleIn;
    @(negedge clk); trigIn = 1'b0;
    checkEq("R4 flag high after trigger", trigFound, 1);
    waitDone(1'b0);
    checkEq("R4 flag high when stopped", trigFound, 1);
    doRead(2'd1, "dir64");
    if (gotQ.size() == 256)
      checkEq("R5 trigger vector at age 32", gotQ[(63 - 32) * 4], trigSample[31:0]);
    else checkEq("R5 trigger vector at age 32", gotQ.size(), 256);

    // R10: re-arm during readout is ignored
    gotQ.delete(); lastCnt = 0;
    @(negedge clk); lenCode = 2'd0; readCmd = 1'b1;
    @(negedge clk); readCmd = 1'b0;
    repeat (10) @(negedge clk);
    rearmCmd = 1'b1;
    @(negedge clk); rearmCmd = 1'b0;
    while (mState == M_READ) @(negedge clk);
    @(negedge clk);
    checkEq("R10 re-arm ignored in readout: words", gotQ.size(), 128);
    checkEq("R10 re-arm ignored in readout: flag", trigFound, 1);

    // R10: re-arm together with trigger
    @(negedge clk); rearmCmd = 1'b1; trigIn = 1'b1;
    @(negedge clk); rearmCmd = 1'b0; trigIn = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R10 re-arm clears flag, trigger dropped", trigFound, 0);

    // R8: readout landing on the final post-trigger store
    rateCode = 3'b111; posCode = 4'd1;
    repeat (20) @(negedge clk);
    gotQ.delete();
    @(negedge clk); trigIn = 1'b1;
    @(negedge clk); trigIn = 1'b0;
    repeat (15) @(negedge clk);
    readCmd = 1'b1;
    @(negedge clk); readCmd = 1'b0;
    repeat (6) @(negedge clk);
    checkEq("R8 read on final store cycle ignored", gotQ.size(), 0);
    checkEq("R4 flag after coincident read", trigFound, 1);
    doRead(2'd0, "coinc");

    // R3: disabled window is not stored
    pulseRearm();
    rateCode = 3'b100;
    @(negedge clk); enable = 1'b0;
    repeat (40) @(negedge clk);
    @(negedge clk); trigIn = 1'b1;
    @(negedge clk); trigIn = 1'b0;
    repeat (4) @(negedge clk);
    checkEq("R3 trigger ignored while disabled", trigFound, 0);
    enable = 1'b1;
    repeat (10) @(negedge clk);
    posCode = 4'd1;
    pulseTrig();
    waitDone(1'b0);
    doRead(2'd1, "R3 enable gap");

    // R9: automatic re-arm
    autoRearm = 1'b1;
    doRead(2'd0, "R9 auto");
    checkEq("R9 flag cleared after auto re-arm", trigFound, 0);
    repeat (20) @(negedge clk);
    pulseTrig();
    waitDone(1'b0);
    doRead(2'd0, "R9 resumed capture");
    autoRearm = 1'b0;

    // R2 directed slow rates, then random mix
    for (int r = 0; r < 4; r++) begin
      if (mState != M_REC) pulseRearm();
      rateCode = 3'(r);
      posCode = 4'd1;
      repeat (100) @(negedge clk);
      pulseTrig();
      waitDone(1'b0);
      doRead(2'd1, "R2 rate");
    end
    for (int it = 0; it < 6; it++) begin
      if (mState != M_REC) pulseRearm();
      rateCode  = 3'($urandom % 8);
      posCode   = 4'($urandom % 16);
      autoRearm = 1'($urandom % 2);
      repeat (20 + $urandom % 100) begin
        @(negedge clk); enable = (($urandom % 8) != 0);
      end
      pulseTrig();
      waitDone(1'b1);
      doRead(2'($urandom % 4), "R2 random");
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule